// File: doc/BRIEF.md
# Switched-Capacitor Pixel Phase Sequencer

This block drives the analog switches of one charge-transfer sensing cycle on a capacitive pixel column. A single start strobe launches a fixed eleven-step switch choreography. The steps precharge the pixel electrode to the high reference and charge a dummy cell to the low reference. They then reset the sense amplifier to its reference and transfer the charge difference onto a first hold capacitor, so that the parasitic capacitance of the electrode cancels against the dummy cell. Last, the output stage is referenced and the held sample is moved to the output hold capacitor. The switches, capacitors and references live outside the block; only their enable wires are produced here.

Each step holds its switch state for a programmable number of clocks, given by `step_len` and captured when the strobe is accepted. Between consecutive steps a separation interval of `GAP_CLKS` clocks keeps on only the switches that are on in both steps, so no switch turns on in the cycle in which another turns off. A one-clock `done` pulse marks the end of the cycle.

Top module: `pxseq_top`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every switch enable and `done` are low from that edge on, whatever step was running; the block is then idle.
- R2: While idle, and before any start, every switch enable and `done` are low.
- R3: A start strobe sampled high at a rising edge while idle puts the step 1 state on the enables from that edge on.
- R4: The step states, named by the enables that are high, are in order: 1 pre+rst+row; 2 rst; 3 rst+dum+xfr; 4 rst; 5 rst+ref; 6 ref; 7 ref+row+xfr+hold1; 8 ref+row+xfr; 9 ref+row+xfr+oref; 10 ref+row+xfr; 11 ref+row+xfr+col+hold2. All other enables are low in each state.
- R5: Each step state lasts exactly N clocks, where N is the unsigned value of `step_len` captured with the accepted start; a value of 0 is taken as 1.
- R6: Between step k and step k+1 the enables show, for exactly `GAP_CLKS` clocks, only the switches high in both states; no enable rises in a cycle in which another falls.
- R7: After step 11, `done` is high for exactly one clock with all enables low, after which the block is idle.
- R8: A start strobe sampled while a sequence is running (in a step, a separation interval or the `done` cycle) has no effect on the enables or on `done`.
- R9: A change of `step_len` while a sequence is running does not alter the length of its steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, sampled at a rising edge |
| step_len | input | LEN_W (8) | Clocks per step, 0 treated as 1 |
| sw_pre | output | 1 | Supply precharge switch enable |
| sw_rst | output | 1 | Integrator reset switch enable |
| sw_row | output | 1 | Row switch enable |
| sw_dum | output | 1 | Dummy-cell charge switch enable |
| sw_xfr | output | 1 | Shared transfer switch enable |
| sw_ref | output | 1 | Sense-line reference switch enable |
| sw_hold1 | output | 1 | First hold capacitor switch enable |
| sw_oref | output | 1 | Output-stage reference switch enable |
| sw_col | output | 1 | Column select switch enable |
| sw_hold2 | output | 1 | Output hold capacitor switch enable |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
All outputs come from registered state with no further register, so the step 1 state appears right after the edge that samples the strobe. Counting t from that edge, step j (from 0) occupies clocks t = 1 + j*(N+G) through j*(N+G)+N, the separation interval follows, and `done` falls on clock 11N+10G+1. Reset takes effect from the edge that samples it low. The bench holds a per-clock expected vector in a queue, pushed just after each rising edge and compared at the following falling edge, so every result is compared in the exact clock in which it is due, including during ignored strobes, length changes and aborts.

// File: rtl/pxseq_pkg.sv
// Shared constants, types and the step pattern table of the pixel phase
// sequencer. Assumes the enable vector bit order given by the SW_* indices.
package pxseq_pkg;

    localparam int NSW       = 10;
    localparam int NSTEP     = 11;
    localparam int IDX_W     = $clog2(NSTEP + 1);

    localparam int SW_PRE    = 0;
    localparam int SW_RST    = 1;
    localparam int SW_ROW    = 2;
    localparam int SW_DUM    = 3;
    localparam int SW_XFR    = 4;
    localparam int SW_REF    = 5;
    localparam int SW_HOLD1  = 6;
    localparam int SW_OREF   = 7;
    localparam int SW_COL    = 8;
    localparam int SW_HOLD2  = 9;

    typedef logic [NSW-1:0] sw_vec_t;

    typedef enum logic [1:0] {
        M_IDLE,
        M_STEP,
        M_GAP,
        M_FIN
    } mode_t;

    // Switch state held during step k (k counts from 0); all off past the end.
    function automatic sw_vec_t step_pattern(input logic [IDX_W-1:0] k);
        sw_vec_t v;
        v = '0;
        case (k)
            4'd0: begin v[SW_PRE] = 1'b1; v[SW_RST] = 1'b1; v[SW_ROW] = 1'b1; end
            4'd1: begin v[SW_RST] = 1'b1; end
            4'd2: begin v[SW_RST] = 1'b1; v[SW_DUM] = 1'b1; v[SW_XFR] = 1'b1; end
            4'd3: begin v[SW_RST] = 1'b1; end
            4'd4: begin v[SW_RST] = 1'b1; v[SW_REF] = 1'b1; end
            4'd5: begin v[SW_REF] = 1'b1; end
            4'd6: begin v[SW_REF] = 1'b1; v[SW_ROW] = 1'b1; v[SW_XFR] = 1'b1;
                        v[SW_HOLD1] = 1'b1; end
            4'd7: begin v[SW_REF] = 1'b1; v[SW_ROW] = 1'b1; v[SW_XFR] = 1'b1; end
            4'd8: begin v[SW_REF] = 1'b1; v[SW_ROW] = 1'b1; v[SW_XFR] = 1'b1;
                        v[SW_OREF] = 1'b1; end
            4'd9: begin v[SW_REF] = 1'b1; v[SW_ROW] = 1'b1; v[SW_XFR] = 1'b1; end
            4'd10: begin v[SW_REF] = 1'b1; v[SW_ROW] = 1'b1; v[SW_XFR] = 1'b1;
                         v[SW_COL] = 1'b1; v[SW_HOLD2] = 1'b1; end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pxseq_timer.sv
// Down-counter that measures one step or one separation interval.
// Assumes load_val is at least 1; last is high in the final clock of the
// interval that the most recent load started.
module pxseq_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             last
);

    logic [LEN_W-1:0] cnt;

    // Count down the clocks remaining in the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Final clock of the interval.
    assign last = (cnt == '0);

    // A zero-length interval would wrap the counter.
    assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/pxseq_pattern.sv
// Decodes sequencer position into switch enables. During a separation
// interval after step idx only switches on in both neighbouring steps stay on.
// Assumes idx stays below NSTEP while active.
module pxseq_pattern
    import pxseq_pkg::*;
(
    input  logic             active,
    input  logic             in_gap,
    input  logic [IDX_W-1:0] idx,
    output sw_vec_t          sw
);

    sw_vec_t cur_pat;
    sw_vec_t nxt_pat;

    // Patterns of the current and the following step.
    always_comb begin
        cur_pat = step_pattern(idx);
        nxt_pat = step_pattern(idx + 1'b1);
    end

    // Select the visible enable set.
    always_comb begin
        if (!active)
            sw = '0;
        else if (in_gap)
            sw = cur_pat & nxt_pat;
        else
            sw = cur_pat;
    end

endmodule

// File: rtl/pxseq_top.sv
// Pixel phase sequencer: runs the eleven-step switch choreography of one
// charge-transfer sensing cycle after a start strobe, with a captured step
// length and GAP_CLKS separation clocks between steps, then pulses done.
// Assumes GAP_CLKS fits in LEN_W bits and is at least 1.
module pxseq_top
    import pxseq_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int GAP_CLKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] step_len,
    output logic             sw_pre,
    output logic             sw_rst,
    output logic             sw_row,
    output logic             sw_dum,
    output logic             sw_xfr,
    output logic             sw_ref,
    output logic             sw_hold1,
    output logic             sw_oref,
    output logic             sw_col,
    output logic             sw_hold2,
    output logic             done
);

    localparam logic [LEN_W-1:0] GAP_VAL   = LEN_W'(GAP_CLKS);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NSTEP - 1);

    mode_t            mode;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] load_val;
    logic             load;
    logic             last;
    sw_vec_t          sw;

    // Requested length with zero promoted to one.
    assign len_eff = (step_len == '0) ? LEN_W'(1) : step_len;

    // Timer reload points and the value loaded at each.
    always_comb begin
        load     = 1'b0;
        load_val = len_q;
        case (mode)
            M_IDLE: begin load = start; load_val = len_eff; end
            M_STEP: begin load = last && (idx != LAST_STEP); load_val = GAP_VAL; end
            M_GAP:  begin load = last; load_val = len_q; end
            default: begin load = 1'b0; load_val = len_q; end
        endcase
    end

    // Sequencer position: mode, step index and captured step length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= M_IDLE;
            idx   <= '0;
            len_q <= LEN_W'(1);
        end else begin
            case (mode)
                M_IDLE: if (start) begin
                    mode  <= M_STEP;
                    idx   <= '0;
                    len_q <= len_eff;
                end
                M_STEP: if (last) begin
                    mode <= (idx == LAST_STEP) ? M_FIN : M_GAP;
                end
                M_GAP: if (last) begin
                    mode <= M_STEP;
                    idx  <= idx + 1'b1;
                end
                default: begin
                    mode <= M_IDLE;
                    idx  <= '0;
                end
            endcase
        end
    end

    pxseq_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    pxseq_pattern u_pattern (
        .active (mode == M_STEP || mode == M_GAP),
        .in_gap (mode == M_GAP),
        .idx    (idx),
        .sw     (sw)
    );

    // Fan the enable vector out to the named ports.
    always_comb begin
        sw_pre   = sw[SW_PRE];
        sw_rst   = sw[SW_RST];
        sw_row   = sw[SW_ROW];
        sw_dum   = sw[SW_DUM];
        sw_xfr   = sw[SW_XFR];
        sw_ref   = sw[SW_REF];
        sw_hold1 = sw[SW_HOLD1];
        sw_oref  = sw[SW_OREF];
        sw_col   = sw[SW_COL];
        sw_hold2 = sw[SW_HOLD2];
        done     = (mode == M_FIN);
    end

    // Reset clears every enable at the next edge.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (sw == '0 && !done));

    // Idle drives nothing.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE) |-> (sw == '0 && !done));

    // No enable rises in a cycle where another falls.
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(sw & ~$past(sw))) && (|(~sw & $past(sw)))));

    // done lasts one clock, with all enables off.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sw == '0));

    // A running sequence never restarts at step 1 without passing idle.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STEP && idx != '0) |=> (mode == M_IDLE || idx != '0));

endmodule

// File: tb/tb_pxseq_top.sv
// Scoreboard bench: the driver pushes the expected enable vector for each
// clock, the monitor pops and compares it at the following falling edge.
module tb_pxseq_top;

    localparam int LEN_W = 8;
    localparam int G     = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] step_len = '0;
    logic sw_pre, sw_rst, sw_row, sw_dum, sw_xfr, sw_ref;
    logic sw_hold1, sw_oref, sw_col, sw_hold2, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pxseq_top #(.LEN_W(LEN_W), .GAP_CLKS(G)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step_len(step_len),
        .sw_pre(sw_pre), .sw_rst(sw_rst), .sw_row(sw_row), .sw_dum(sw_dum),
        .sw_xfr(sw_xfr), .sw_ref(sw_ref), .sw_hold1(sw_hold1),
        .sw_oref(sw_oref), .sw_col(sw_col), .sw_hold2(sw_hold2), .done(done)
    );

    // Observed vector: bit 10 done, bits 9..0 hold2 col oref hold1 ref xfr dum row rst pre.
    function automatic logic [10:0] observed();
        return {done, sw_hold2, sw_col, sw_oref, sw_hold1, sw_ref,
                sw_xfr, sw_dum, sw_row, sw_rst, sw_pre};
    endfunction

    // Step states from the requirement R4, same bit order.
    function automatic logic [10:0] pat(input int j);
        case (j)
            0:  return 11'b000_0000_0111;
            1:  return 11'b000_0000_0010;
            2:  return 11'b000_0001_1010;
            3:  return 11'b000_0000_0010;
            4:  return 11'b000_0010_0010;
            5:  return 11'b000_0010_0000;
            6:  return 11'b000_0111_0100;
            7:  return 11'b000_0011_0100;
            8:  return 11'b000_1011_0100;
            9:  return 11'b000_0011_0100;
            10: return 11'b011_0011_0100;
            default: return 11'b0;
        endcase
    endfunction

    // Expected vector t clocks after the edge that accepted start (t=0 before it).
    function automatic logic [10:0] expect_at(input int n, input int t);
        int u;
        if (t == 0) return 11'b0;
        u = t - 1;
        for (int j = 0; j < 11; j++) begin
            int b;
            b = j * (n + G);
            if (u >= b && u < b + n) return pat(j);
            if (j < 10 && u >= b + n && u < b + n + G) return pat(j) & pat(j + 1);
        end
        if (u == 11 * n + 10 * G) return 11'b100_0000_0000;
        return 11'b0;
    endfunction

    function automatic string tag_at(input int n, input int t);
        int u;
        if (t == 0) return "R2";
        if (t == 1) return "R3";
        u = t - 1;
        if (u == 11 * n + 10 * G) return "R7";
        if (u > 11 * n + 10 * G) return "R7 idle";
        if ((u % (n + G)) >= n) return "R6";
        return "R4/R5";
    endfunction

    // Monitor: compare each expected item in the clock it is due.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [10:0] e;
                string       tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (observed() !== e) begin
                    fails++;
                    $display("FAIL %s: actual %b expected %b at %0t", tg, observed(), e, $time);
                end
            end
        end
    end

    // Driver: one sensing cycle with optional busy start, length change and abort.
    task automatic run_seq(input int len, input int ign_at, input int chg_at,
                           input int abort_at, input string note);
        int n;
        int total;
        n = (len == 0) ? 1 : len;
        total = 11 * n + 10 * G + 1;
        @(posedge clk); #1;
        start    = 1'b1;
        step_len = LEN_W'(len);
        exp_q.push_back(expect_at(n, 0));
        tag_q.push_back({"R2 ", note});
        for (int t = 1; t <= total + 1; t++) begin
            @(posedge clk); #1;
            if (abort_at > 0 && t > abort_at) begin
                exp_q.push_back(11'b0);
                tag_q.push_back({"R1 ", note});
            end else begin
                exp_q.push_back(expect_at(n, t));
                tag_q.push_back({tag_at(n, t), " ", note});
            end
            start = (t == ign_at);
            if (t == chg_at) step_len = LEN_W'(7);
            if (abort_at > 0 && t == abort_at) rst_n = 1'b0;
            if (abort_at > 0 && t == abort_at + 1) rst_n = 1'b1;
        end
        start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        // R1 reset state.
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            exp_q.push_back(11'b0);
            tag_q.push_back("R1 reset");
        end
        rst_n = 1'b1;
        run_seq(1, 0, 0, 0, "len1");
        run_seq(3, 0, 0, 0, "len3");
        // R5: zero length runs as one.
        run_seq(0, 0, 0, 0, "R5 len0");
        // R8: start during a step and in a separation interval; R9: length change.
        run_seq(3, 7, 5, 0, "R8 R9 busy");
        run_seq(3, 4, 0, 0, "R8 gap");
        // R8: start during the done cycle (t = 11*2+10*G+1).
        run_seq(2, 11 * 2 + 10 * G + 1, 0, 0, "R8 fin");
        // R1: reset in the middle of step 7.
        run_seq(2, 0, 0, 6 * (2 + G) + 2, "R1 abort");
        run_seq(2, 0, 0, 0, "after abort");
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule